// File: doc/BRIEF.md
# Flash Security and Access Gate

This block keeps a one-way security byte and a small register-backed model of the on-chip code store, and decides who may see that code. It has two modes, picked by a mode input. In programming mode a single command port accepts four operations: byte read, byte program, whole-chip erase and identification read. In run mode a table-read port asks for a byte of program memory. The block answers from the internal store or sends the request out to the external bus. Its choice depends on the address and on whether the requesting instruction itself sits in external memory.

Security bits can only be cleared. Programming ANDs new data into the byte, and only a whole-chip erase sets the byte back to all ones, together with the code store. Bit 0 is the read lock and bit 1 the table-read restriction. Bit 2 drives an encryption-enable output, which is asserted when the bit is 0. Bit 7 drives the oscillator gain select. Bits 3 to 6 are reserved and always stay at 1. High-voltage timing and any encryption algorithm lie outside this block.

Top module: `flash_guard`

## Requirements
- R1: While reset is held and just after it, the security byte reads FFh and every store byte reads FFh. The outputs pg_rvalid and tr_rvalid are 0, tr_ext is 0, pg_rdata and tr_rdata are FFh, osc_full_gain is 1 and encrypt_en is 0.
- R2: Command codes on pg_cmd are 0 read, 1 program, 2 erase and 3 identification read. A program to an address from 0000h to 3FFFh ANDs pg_wdata into the store byte selected by the low address bits. A read or identification read is answered on the next clock, with pg_rvalid high for one cycle and the byte on pg_rdata.
- R3: The security byte sits at address FFFFh. A program there ANDs pg_wdata into it while bits 3 to 6 stay 1, and a read there returns it.
- R4: An erase returns every store byte and the security byte to FFh. It also restores osc_full_gain to 1 and encrypt_en to 0.
- R5: An identification read with address bit 0 at 0 returns DAh, and with address bit 0 at 1 it returns 61h.
- R6: While security bit 0 is 0, every programming-mode read returns FFh. This covers store, security byte and identification reads.
- R7: While security bit 1 is 0, a table read with tr_from_ext high is redirected: on the next clock tr_ext=1 and tr_rdata=FFh. With tr_from_ext low, or with bit 1 at 1, an internal address is served from the store with tr_ext=0.
- R8: A table read to an address above 3FFFh is always redirected (tr_ext=1, tr_rdata=FFh).
- R9: osc_full_gain follows security bit 7, and encrypt_en is the inverse of security bit 2.
- R10: While prog_mode is 0, the programming port is ignored. While prog_mode is 1, table reads are ignored and tr_rvalid stays 0.
- R11: A program to an address that is neither in the store range nor FFFFh changes nothing. A read of such an address returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the erased state |
| prog_mode | input | 1 | 1 selects programming mode, 0 selects run mode |
| pg_valid | input | 1 | Programming command present |
| pg_cmd | input | 2 | 0 read, 1 program, 2 erase, 3 identification read |
| pg_addr | input | 16 | Programming address |
| pg_wdata | input | 8 | Data to program |
| pg_rvalid | output | 1 | Read answer valid |
| pg_rdata | output | 8 | Read answer |
| tr_valid | input | 1 | Table-read request present |
| tr_addr | input | 16 | Table-read address |
| tr_from_ext | input | 1 | Requesting instruction is in external memory |
| tr_rvalid | output | 1 | Table-read answer valid |
| tr_ext | output | 1 | Request redirected to the external bus |
| tr_rdata | output | 8 | Internal byte, FFh when redirected |
| osc_full_gain | output | 1 | Oscillator gain select (security bit 7) |
| encrypt_en | output | 1 | Encryption enable (security bit 2 is 0) |

## Verification
Two things can meet in one clock: a programming command and a table read. The bench provokes this by presenting both at once with prog_mode at 0. The command tries to clear every security bit, and the table read comes from internal code. It then judges the result at the ports in two ways. The table read must be served from the store as the unchanged security byte allows, with no read answer on the programming side. A later security read in programming mode must return the byte as it stood before. The opposite case, a table read presented in programming mode, must leave tr_rvalid low.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_WORDS = 64,
  parameter logic [ADDR_W-1:0] INT_TOP  = 16'h3FFF,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'hFFFF,
  parameter logic [7:0] ID_MAKER = 8'hDA,
  parameter logic [7:0] ID_PART  = 8'h61,
  parameter logic [7:0] RSV_MASK = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              pg_valid,
  input  logic [1:0]        pg_cmd,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [7:0]        pg_wdata,
  output logic              pg_rvalid,
  output logic [7:0]        pg_rdata,
  input  logic              tr_valid,
  input  logic [ADDR_W-1:0] tr_addr,
  input  logic              tr_from_ext,
  output logic              tr_rvalid,
  output logic              tr_ext,
  output logic [7:0]        tr_rdata,
  output logic              osc_full_gain,
  output logic              encrypt_en
);
  localparam int IDX_W = $clog2(ARRAY_WORDS);
  localparam logic [1:0] C_READ = 2'd0, C_PROG = 2'd1, C_ERASE = 2'd2, C_ID = 2'd3;

  logic [7:0] mem [ARRAY_WORDS];
  logic [7:0] sec_q;
  logic [7:0] rd_byte;

  wire pg_go     = prog_mode & pg_valid;
  wire tr_go     = ~prog_mode & tr_valid;
  wire pg_in_arr = pg_addr <= INT_TOP;
  wire pg_is_sec = pg_addr == SEC_ADDR;
  wire pg_is_rd  = (pg_cmd == C_READ) | (pg_cmd == C_ID);
  wire [IDX_W-1:0] pg_idx = pg_addr[IDX_W-1:0];
  wire [IDX_W-1:0] tr_idx = tr_addr[IDX_W-1:0];
  wire locked    = ~sec_q[0];
  wire tr_inside = (tr_addr <= INT_TOP) & (~tr_from_ext | sec_q[1]);

  assign osc_full_gain = sec_q[7];
  assign encrypt_en    = ~sec_q[2];

  always_comb begin
    rd_byte = 8'hFF;
    if (!locked) begin
      if (pg_cmd == C_ID)
        rd_byte = pg_addr[0] ? ID_PART : ID_MAKER;
      else if (pg_is_sec)
        rd_byte = sec_q;
      else if (pg_in_arr)
        rd_byte = mem[pg_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_WORDS; i++) mem[i] <= 8'hFF;
      sec_q <= 8'hFF;
    end else if (pg_go) begin
      if (pg_cmd == C_ERASE) begin
        for (int i = 0; i < ARRAY_WORDS; i++) mem[i] <= 8'hFF;
        sec_q <= 8'hFF;
      end else if (pg_cmd == C_PROG) begin
        if (pg_is_sec) sec_q <= sec_q & (pg_wdata | RSV_MASK);
        else if (pg_in_arr) mem[pg_idx] <= mem[pg_idx] & pg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_rvalid <= 1'b0;
      pg_rdata  <= 8'hFF;
      tr_rvalid <= 1'b0;
      tr_ext    <= 1'b0;
      tr_rdata  <= 8'hFF;
    end else begin
      pg_rvalid <= pg_go & pg_is_rd;
      if (pg_go & pg_is_rd) pg_rdata <= rd_byte;
      tr_rvalid <= tr_go;
      if (tr_go) begin
        tr_ext   <= ~tr_inside;
        tr_rdata <= tr_inside ? mem[tr_idx] : 8'hFF;
      end
    end
  end

  p_reserved_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q & RSV_MASK) == RSV_MASK);

  p_answer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rvalid |-> $past(prog_mode && pg_valid && (pg_cmd == C_READ || pg_cmd == C_ID)));

  p_locked_reads_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && pg_valid && pg_is_rd && locked) |=> (pg_rdata == 8'hFF));

  p_sec_only_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(prog_mode && pg_valid && pg_cmd == C_ERASE) |-> ((sec_q & ~$past(sec_q)) == 8'h00));

  p_ext_code_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && tr_valid && tr_from_ext && !sec_q[1]) |=> tr_ext);

  p_high_addr_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && tr_valid && tr_addr > INT_TOP) |=> (tr_ext && tr_rdata == 8'hFF));

  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_rvalid && tr_rvalid));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  logic clk = 0, rst_n = 0, prog_mode = 0, pg_valid = 0, tr_valid = 0, tr_from_ext = 0;
  logic [1:0] pg_cmd = 0;
  logic [15:0] pg_addr = 0, tr_addr = 0;
  logic [7:0] pg_wdata = 0;
  logic pg_rvalid, tr_rvalid, tr_ext, osc_full_gain, encrypt_en;
  logic [7:0] pg_rdata, tr_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_guard uut (.clk, .rst_n, .prog_mode, .pg_valid, .pg_cmd, .pg_addr, .pg_wdata,
    .pg_rvalid, .pg_rdata, .tr_valid, .tr_addr, .tr_from_ext, .tr_rvalid, .tr_ext,
    .tr_rdata, .osc_full_gain, .encrypt_en);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pg_do(input logic [1:0] c, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_mode = 1; pg_valid = 1; pg_cmd = c; pg_addr = a; pg_wdata = d;
    @(posedge clk); @(negedge clk);
    pg_valid = 0;
  endtask

  task automatic pg_read(input string tag, input logic [1:0] c, input logic [15:0] a, input logic [7:0] exp);
    pg_do(c, a, 8'h00);
    chk({tag, " rvalid"}, pg_rvalid, 1);
    chk(tag, pg_rdata, exp);
  endtask

  task automatic tr_do(input string tag, input logic [15:0] a, input logic fe,
                       input logic exp_ext, input logic [7:0] exp_d);
    @(negedge clk);
    prog_mode = 0; tr_valid = 1; tr_addr = a; tr_from_ext = fe;
    @(posedge clk); @(negedge clk);
    tr_valid = 0;
    chk({tag, " tr_rvalid"}, tr_rvalid, 1);
    chk({tag, " tr_ext"}, tr_ext, exp_ext);
    chk({tag, " tr_rdata"}, tr_rdata, exp_d);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 pg_rvalid in reset", pg_rvalid, 0);
    chk("R1 tr_rvalid in reset", tr_rvalid, 0);
    chk("R1 tr_ext in reset", tr_ext, 0);
    chk("R1 pg_rdata in reset", pg_rdata, 8'hFF);
    chk("R1 tr_rdata in reset", tr_rdata, 8'hFF);
    chk("R1 gain in reset", osc_full_gain, 1);
    chk("R1 encrypt in reset", encrypt_en, 0);
    rst_n = 1;
    pg_read("R1 security after reset", 2'd0, 16'hFFFF, 8'hFF);
    pg_read("R1 store after reset", 2'd0, 16'h0005, 8'hFF);
  endtask

  task automatic t_program;
    pg_do(2'd1, 16'h0005, 8'hA5);
    pg_read("R2 first program", 2'd0, 16'h0005, 8'hA5);
    pg_do(2'd1, 16'h0005, 8'h3C);
    pg_read("R2 program ANDs", 2'd0, 16'h0005, 8'h24);
    pg_do(2'd1, 16'h0005, 8'h00);
    chk("R2 no answer to program", pg_rvalid, 0);
    pg_do(2'd2, 16'h0000, 8'h00);
    pg_do(2'd1, 16'h0005, 8'h24);
    pg_read("R2 reprogram after erase", 2'd0, 16'h0005, 8'h24);
  endtask

  task automatic t_ident;
    pg_read("R5 maker id", 2'd3, 16'h0000, 8'hDA);
    pg_read("R5 part id", 2'd3, 16'h0001, 8'h61);
  endtask

  task automatic t_outside;
    pg_do(2'd1, 16'h8000, 8'h00);
    pg_read("R11 outside read", 2'd0, 16'h8000, 8'hFF);
    pg_read("R11 alias cell untouched", 2'd0, 16'h0000, 8'hFF);
    pg_read("R11 security untouched", 2'd0, 16'hFFFF, 8'hFF);
  endtask

  task automatic t_table_open;
    tr_do("R7 ext code open", 16'h0005, 1'b1, 1'b0, 8'h24);
    tr_do("R8 high address", 16'h4000, 1'b0, 1'b1, 8'hFF);
  endtask

  task automatic t_table_restrict;
    pg_do(2'd1, 16'hFFFF, 8'hFD);
    pg_read("R3 clear bit1", 2'd0, 16'hFFFF, 8'hFD);
    chk("R9 gain unchanged", osc_full_gain, 1);
    chk("R9 encrypt unchanged", encrypt_en, 0);
    tr_do("R7 ext code blocked", 16'h0005, 1'b1, 1'b1, 8'hFF);
    tr_do("R7 int code allowed", 16'h0005, 1'b0, 1'b0, 8'h24);
  endtask

  task automatic t_modes;
    @(negedge clk);
    prog_mode = 0; pg_valid = 1; pg_cmd = 2'd1; pg_addr = 16'hFFFF; pg_wdata = 8'h00;
    tr_valid = 1; tr_addr = 16'h0005; tr_from_ext = 0;
    @(posedge clk); @(negedge clk);
    pg_valid = 0; tr_valid = 0;
    chk("R10 table served", tr_rvalid, 1);
    chk("R10 table internal", tr_ext, 0);
    chk("R10 table data", tr_rdata, 8'h24);
    chk("R10 no prog answer", pg_rvalid, 0);
    pg_read("R10 security kept", 2'd0, 16'hFFFF, 8'hFD);
    @(negedge clk);
    prog_mode = 1; tr_valid = 1; tr_addr = 16'h0005;
    @(posedge clk); @(negedge clk);
    tr_valid = 0;
    chk("R10 table ignored in prog mode", tr_rvalid, 0);
  endtask

  task automatic t_outputs_lock;
    pg_do(2'd1, 16'hFFFF, 8'h7B);
    pg_read("R3 reserved stay 1", 2'd0, 16'hFFFF, 8'h79);
    chk("R9 half gain", osc_full_gain, 0);
    chk("R9 encrypt on", encrypt_en, 1);
    pg_do(2'd1, 16'hFFFF, 8'h00);
    pg_read("R6 locked security", 2'd0, 16'hFFFF, 8'hFF);
    pg_read("R6 locked store", 2'd0, 16'h0005, 8'hFF);
    pg_read("R6 locked id", 2'd3, 16'h0000, 8'hFF);
  endtask

  task automatic t_erase;
    pg_do(2'd2, 16'h0000, 8'h00);
    pg_read("R4 security erased", 2'd0, 16'hFFFF, 8'hFF);
    pg_read("R4 store erased", 2'd0, 16'h0005, 8'hFF);
    chk("R4 gain restored", osc_full_gain, 1);
    chk("R4 encrypt off", encrypt_en, 0);
    tr_do("R4 table after erase", 16'h0005, 1'b1, 1'b0, 8'hFF);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset;
    t_program;
    t_ident;
    t_outside;
    t_table_open;
    t_table_restrict;
    t_modes;
    t_outputs_lock;
    t_erase;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run;
  end
endmodule